// File: doc/BRIEF.md
# Paged SPI Register Command Decoder

This block sits on the slave side of a serial link that moves 16-bit words. It takes each word from the SPI bit shifter and treats the words alternately as a command and as data. A command word carries the transfer direction, a register page and a register offset. The data word that follows is either stored into the addressed register or used as a dummy slot during which the addressed register is read out. The register banks sit outside this block and are reached through a single-cycle read/write strobe port.

Reads move the offset forward by one each time. A host can therefore stream a run of registers by sending all-zero words after one read command. Writing the key value 0xBB00 to the reset register on the control page raises a soft-reset strobe and returns the decoder to its idle state. The decoder reports malformed traffic with one-cycle flags: wrong word length, illegal page, overrun and underrun.

Top module: `spi_paged_cmd_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the decoder returns to the command phase with page 0, offset 0, the read flag clear, `word_out` at 0 and every pulse output low.
- R2: A nonzero 16-bit word received in the command phase is a command. Bit 15 set means read, bits 14:11 are the page and bits 10:5 are the offset. A command word causes no bank strobe.
- R3: After a write command, the next word asserts `bank_wr` for exactly that cycle, with `bank_page`/`bank_addr` from the command and `bank_wdata` equal to the word, for pages 1 and 2. The decoder then goes back to the command phase.
- R4: After a read command, the next word asserts `bank_rd` in that cycle. One cycle later `word_out_valid` pulses and `word_out` holds the `bank_rdata` sampled at that edge. The offset then advances by one and the decoder goes back to the command phase.
- R5: An all-zero word in the command phase reads the current page and offset and then advances the offset, so repeated zero words walk through the registers. The offset wraps from 63 to 0.
- R6: A read returns 0xFFFF when `bank_hit` is low, or when the page is 3 or above. An access to a page of 3 or above raises `page_err` and issues no strobe.
- R7: A write addressed to page 0, the read-only result page, issues no strobe and changes no output.
- R8: Writing exactly 0xBB00 to page 1, offset 4 pulses `soft_rst` and clears the page, offset and read flag. Any other value written there does nothing. Neither case issues `bank_wr`.
- R9: A nonzero word received in the data slot of a read pulses `overrun`. The read is still carried out, and the word is not taken as a command.
- R10: An all-zero word in the command phase pulses `underrun` when the last command was not a read (including after a reset). The read is still carried out.
- R11: A word whose `word_len` is not 16 pulses `len_err` and is discarded. The phase, page and offset are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | A received word is present this cycle |
| word_len | input | 5 | Number of bits in the received word |
| word_in | input | 16 | Received word |
| word_out | output | 16 | Read result for the shifter to return |
| word_out_valid | output | 1 | Pulses when `word_out` is updated |
| bank_rd | output | 1 | Bank read strobe |
| bank_wr | output | 1 | Bank write strobe |
| bank_page | output | 4 | Page being accessed |
| bank_addr | output | 6 | Offset being accessed |
| bank_wdata | output | 16 | Write data |
| bank_rdata | input | 16 | Read data from the selected bank |
| bank_hit | input | 1 | The addressed register exists |
| soft_rst | output | 1 | Soft-reset pulse |
| len_err | output | 1 | Bad word length pulse |
| page_err | output | 1 | Illegal page access pulse |
| overrun | output | 1 | Data during a pending read pulse |
| underrun | output | 1 | Read with no read command pending pulse |

## Verification
The decoder is driven with directed command/data pairs on every legal page, both for registers that exist and for ones that do not. Each result tells apart routing by page, decoding of the offset bits and the substitution of 0xFFFF. Runs of zero words that cross offset 63 separate sequential reads from plain command reads and check the wrap. Single misuse cases cover the reset key against a near-miss value, a nonzero dummy word, a zero word after a write and a short word, and each one exposes one error flag and whether the phase survived. A long seeded random mix of commands, zero words, key values and bad lengths is then compared word by word against a reference model.

// File: rtl/spi_paged_cmd_decoder.sv
module spi_paged_cmd_decoder #(
  parameter int DW         = 16,
  parameter int PW         = 4,
  parameter int OW         = 6,
  parameter int LW         = 5,
  parameter int NPAGES     = 3,
  parameter int DATA_PAGE  = 0,
  parameter int CTRL_PAGE  = 1,
  parameter int RST_OFFSET = 4,
  parameter logic [15:0] RST_KEY  = 16'hBB00,
  parameter logic [15:0] NO_REG   = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_valid,
  input  logic [LW-1:0] word_len,
  input  logic [DW-1:0] word_in,
  output logic [DW-1:0] word_out,
  output logic          word_out_valid,
  output logic          bank_rd,
  output logic          bank_wr,
  output logic [PW-1:0] bank_page,
  output logic [OW-1:0] bank_addr,
  output logic [DW-1:0] bank_wdata,
  input  logic [DW-1:0] bank_rdata,
  input  logic          bank_hit,
  output logic          soft_rst,
  output logic          len_err,
  output logic          page_err,
  output logic          overrun,
  output logic          underrun
);
  localparam int PAGE_MSB = DW - 2;
  localparam int OFF_MSB  = DW - 2 - PW;

  logic          data_ph_q;
  logic          rd_q;
  logic [PW-1:0] page_q;
  logic [OW-1:0] off_q;

  wire len_ok   = word_len == LW'(DW);
  wire take     = word_valid && len_ok;
  wire is_zero  = word_in == '0;
  wire seq_rd   = take && !data_ph_q && is_zero;
  wire cmd_w    = take && !data_ph_q && !is_zero;
  wire slot_rd  = take && data_ph_q && rd_q;
  wire slot_wr  = take && data_ph_q && !rd_q;
  wire do_rd    = seq_rd || slot_rd;
  wire page_ok  = page_q < PW'(NPAGES);
  wire rst_reg  = (page_q == PW'(CTRL_PAGE)) && (off_q == OW'(RST_OFFSET));
  wire key_hit  = slot_wr && rst_reg && (word_in == RST_KEY);

  assign bank_rd    = do_rd && page_ok;
  assign bank_wr    = slot_wr && page_ok && (page_q != PW'(DATA_PAGE)) && !rst_reg;
  assign bank_page  = page_q;
  assign bank_addr  = off_q;
  assign bank_wdata = word_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_ph_q      <= 1'b0;
      rd_q           <= 1'b0;
      page_q         <= '0;
      off_q          <= '0;
      word_out       <= '0;
      word_out_valid <= 1'b0;
      soft_rst       <= 1'b0;
      len_err        <= 1'b0;
      page_err       <= 1'b0;
      overrun        <= 1'b0;
      underrun       <= 1'b0;
    end else begin
      word_out_valid <= 1'b0;
      soft_rst       <= 1'b0;
      len_err        <= word_valid && !len_ok;
      page_err       <= 1'b0;
      overrun        <= 1'b0;
      underrun       <= 1'b0;
      if (cmd_w) begin
        rd_q      <= word_in[DW-1];
        page_q    <= word_in[PAGE_MSB -: PW];
        off_q     <= word_in[OFF_MSB -: OW];
        data_ph_q <= 1'b1;
      end
      if (do_rd) begin
        word_out       <= (page_ok && bank_hit) ? bank_rdata : NO_REG;
        word_out_valid <= 1'b1;
        off_q          <= off_q + 1'b1;
        page_err       <= !page_ok;
        underrun       <= seq_rd && !rd_q;
        overrun        <= slot_rd && !is_zero;
        data_ph_q      <= 1'b0;
      end
      if (slot_wr) begin
        data_ph_q <= 1'b0;
        page_err  <= !page_ok;
        if (key_hit) begin
          soft_rst <= 1'b1;
          page_q   <= '0;
          off_q    <= '0;
          rd_q     <= 1'b0;
        end
      end
    end
  end

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bank_rd, bank_wr}));

  assert_no_data_page_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |-> bank_page != PW'(DATA_PAGE));

  assert_rd_returns_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd |=> word_out_valid);

  assert_key_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> ($past(word_in) == RST_KEY) && $past(word_valid));

  assert_bad_len_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> !word_out_valid && !soft_rst && !page_err);

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(overrun && underrun));
endmodule

// File: tb/spi_paged_cmd_decoder_tb_top.sv
module spi_paged_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [4:0]  word_len = 5'd16;
  logic [15:0] word_in = '0;
  logic [15:0] word_out, bank_wdata, bank_rdata;
  logic        word_out_valid, bank_rd, bank_wr, bank_hit;
  logic [3:0]  bank_page;
  logic [5:0]  bank_addr;
  logic        soft_rst, len_err, page_err, overrun, underrun;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign bank_rdata = {bank_page, 2'b10, bank_addr, 4'h5};
  assign bank_hit   = bank_addr < 6'd40;

  spi_paged_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_len(word_len),
    .word_in(word_in), .word_out(word_out), .word_out_valid(word_out_valid),
    .bank_rd(bank_rd), .bank_wr(bank_wr), .bank_page(bank_page),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
    .bank_hit(bank_hit), .soft_rst(soft_rst), .len_err(len_err),
    .page_err(page_err), .overrun(overrun), .underrun(underrun)
  );

  logic       m_ph, m_rd;
  logic [3:0] m_pg;
  logic [5:0] m_off;

  function automatic logic [15:0] exp_rdata(input logic [3:0] pg, input logic [5:0] off);
    if (pg >= 4'd3 || off >= 6'd40) return 16'hFFFF;
    return {pg, 2'b10, off, 4'h5};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ph = 0; m_rd = 0; m_pg = 0; m_off = 0;
  endtask

  task automatic send(input logic [4:0] len, input logic [15:0] w);
    logic e_rd, e_wr, e_v, e_sr, e_le, e_pe, e_ov, e_un;
    logic [15:0] e_out;
    logic [3:0] a_pg;
    logic [5:0] a_off;
    string tag;
    logic [63:0] act, exp;
    e_rd = 0; e_wr = 0; e_v = 0; e_sr = 0; e_le = 0; e_pe = 0; e_ov = 0; e_un = 0;
    e_out = 0; a_pg = m_pg; a_off = m_off; tag = "R2";
    if (len != 5'd16) begin
      e_le = 1; tag = "R11";
    end else if (!m_ph && w == 0) begin
      e_un = !m_rd; tag = e_un ? "R10" : "R5";
      e_rd = m_pg < 3; e_v = 1; e_pe = !(m_pg < 3); e_out = exp_rdata(m_pg, m_off);
      if (e_out == 16'hFFFF) tag = "R6";
      m_off = m_off + 1; m_ph = 0;
    end else if (!m_ph) begin
      m_rd = w[15]; m_pg = w[14:11]; m_off = w[10:5]; m_ph = 1; tag = "R2";
    end else if (m_rd) begin
      e_ov = w != 0; tag = e_ov ? "R9" : "R4";
      e_rd = m_pg < 3; e_v = 1; e_pe = !(m_pg < 3); e_out = exp_rdata(m_pg, m_off);
      if (e_out == 16'hFFFF) tag = "R6";
      m_off = m_off + 1; m_ph = 0;
    end else begin
      logic rr;
      rr = (m_pg == 1) && (m_off == 4);
      e_pe = !(m_pg < 3);
      e_wr = (m_pg < 3) && (m_pg != 0) && !rr;
      tag = rr ? "R8" : (m_pg == 0) ? "R7" : e_pe ? "R6" : "R3";
      if (rr && w == 16'hBB00) begin
        e_sr = 1; m_pg = 0; m_off = 0; m_rd = 0;
      end
      m_ph = 0;
    end
    @(negedge clk);
    word_valid = 1; word_len = len; word_in = w;
    #5;
    act = {bank_rd, bank_wr, (bank_rd | bank_wr) ? {bank_page, bank_addr} : 10'd0,
           bank_wr ? bank_wdata : 16'd0};
    exp = {e_rd, e_wr, (e_rd | e_wr) ? {a_pg, a_off} : 10'd0, e_wr ? w : 16'd0};
    check({tag, " strobe"}, act, exp);
    @(negedge clk);
    word_valid = 0;
    act = {word_out_valid, word_out_valid ? word_out : 16'd0, soft_rst, len_err,
           page_err, overrun, underrun};
    exp = {e_v, e_out, e_sr, e_le, e_pe, e_ov, e_un};
    check({tag, " result"}, act, exp);
  endtask

  function automatic logic [15:0] cmdw(input bit rd, input logic [3:0] pg, input logic [5:0] off);
    return {rd, pg, off, 5'b00001};
  endfunction

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle", {44'd0, word_out, word_out_valid, soft_rst, len_err, page_err,
          overrun, underrun, bank_rd, bank_wr},
          64'd0);
    send(16, 16'h0000);
    send(16, cmdw(0, 2, 7));  send(16, 16'h1234);
    send(16, cmdw(1, 1, 3));  send(16, 16'h0000); send(16, 16'h0000);
    send(16, cmdw(1, 2, 62)); send(16, 16'h0000); send(16, 16'h0000); send(16, 16'h0000);
    send(16, cmdw(1, 1, 45)); send(16, 16'h0000);
    send(16, cmdw(1, 5, 2));  send(16, 16'h0000);
    send(16, cmdw(0, 7, 2));  send(16, 16'hABCD);
    send(16, cmdw(0, 0, 3));  send(16, 16'h5555);
    send(16, cmdw(0, 1, 4));  send(16, 16'hBB01);
    send(16, cmdw(1, 1, 4));  send(16, 16'h0000);
    send(16, cmdw(0, 1, 4));  send(16, 16'hBB00);
    send(16, 16'h0000);
    send(16, cmdw(1, 2, 9));  send(16, 16'h00FF); send(16, 16'h0000);
    send(8, 16'h8800);        send(16, cmdw(1, 2, 1)); send(3, 16'h1111); send(16, 16'h0000);
    send(16, cmdw(0, 2, 5));  send(16, 16'h0000); send(16, 16'h0000);
    begin
      logic [3:0] pages [5];
      int unsigned s;
      pages[0] = 0; pages[1] = 1; pages[2] = 2; pages[3] = 3; pages[4] = 9;
      s = $urandom(32'h5eed);
      for (int i = 0; i < 800; i++) begin
        int r;
        logic [15:0] w;
        r = $urandom % 12;
        w = {1'($urandom), pages[$urandom % 5], 6'($urandom), 5'($urandom)};
        if (r == 0) send(5'($urandom % 16), 16'($urandom));
        else if (r < 4) send(16, 16'h0000);
        else if (r == 4) send(16, 16'hBB00);
        else if (r == 5) send(16, cmdw(0, 1, 4));
        else send(16, w);
      end
    end
    rst_n = 0;
    model_reset();
    @(negedge clk);
    rst_n = 1;
    send(16, 16'h0000);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule